// File: doc/BRIEF.md
# Byte-Register I2C Target with Clock Stretching and Mode-Based Write Lock

This block is an I2C target that exposes a 256-entry byte register file to a bus host. It listens on synchronised copies of SCL and SDA and detects START and STOP conditions. It decodes a 7-bit device address and serves either host writes or host reads. SDA and SCL are never driven high. The block only pulls a line low, through an active-high output enable, and the pad and pull-up sit outside it.

After the last bit of each byte it accepts, the block holds SCL low and raises a processing request. It keeps SCL low until the surrounding logic answers with a one-cycle done pulse, and only then does it drive the ACK bit. In a host write, the first data byte loads the register pointer. Each byte after that goes to the pointer location, and the pointer then steps by one. A host read returns bytes from the current pointer, and the pointer steps after each byte sent. A mode input selects between normal and setup access. In normal mode a fixed set of register indices refuses writes. The device address lives in register 0xFE, so the host can move the target to a new address at run time.

States: `ST_IDLE` (bus ignored), `ST_ADDR` (shift the address byte), `ST_DATA` (shift a write byte), `ST_HOLD` (SCL held low, waiting for done), `ST_ACK` (drive ACK low for one SCL pulse), `ST_SEND` (shift a read byte out), `ST_HACK` (sample the host's ACK/NAK). Transitions: STOP sends any state to `ST_IDLE`. START, including a repeated START, sends any state to `ST_ADDR`. `ST_ADDR` goes to `ST_HOLD` on a matching address after the eighth SCL fall, and otherwise to `ST_IDLE`. `ST_DATA` goes to `ST_HOLD` after the eighth fall. `ST_HOLD` goes to `ST_ACK` on done. `ST_ACK` goes at the SCL fall to `ST_SEND` for a read or to `ST_DATA` for a write. `ST_SEND` goes to `ST_HACK` after the eighth fall. `ST_HACK` goes at the fall to `ST_SEND` on ACK or to `ST_IDLE` on NAK.

Top module: `i2c_regslave`

## Requirements
- R1: While reset is asserted, and after it is released, the block drives neither line: scl_oe, sda_oe and proc_req are all 0.
- R2: The block compares the upper seven bits of the first byte after START with the device address. Bit 0 of that byte selects the direction: 0 is a host write and 1 is a host read. On a mismatch the block leaves SDA released, so the host sees NAK, and it never raises proc_req for that transfer.
- R3: For every accepted byte (a matching address byte or a write data byte), the block holds scl_oe and proc_req high from the SCL fall after bit 8 until the cycle after proc_done is seen. It never drives SDA while it stretches the clock.
- R4: Every accepted byte is acknowledged by SDA low during the ninth clock. This includes data bytes aimed at write-locked registers.
- R5: The first data byte of a host write loads the register pointer. Each later byte is stored at the pointer, and the pointer then increments by one.
- R6: A host read sends the register at the pointer, MSB first. The pointer increments after every byte sent. The read continues while the host ACKs and ends on a host NAK.
- R7: With setup_mode=0, writes to indices 0x06–0x09, 0x0C, 0x0D, 0x10–0x17, 0x50, 0x51, 0x57–0x60 and 0x7E are dropped, but the pointer still advances.
- R8: With setup_mode=1, every register, including the ones listed in R7, accepts writes.
- R9: Register 0xFE holds the device address in bits 6:0 and resets to 0x3A. After a write to it, the next START matches only the new address.
- R10: A STOP or a repeated START returns the block to address reception and leaves the pointer unchanged. The block starts driving SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, well above 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sensed level of the SCL line |
| sda_in | input | 1 | Sensed level of the SDA line |
| setup_mode | input | 1 | 1 selects setup access (no write lock), 0 selects normal access |
| proc_done | input | 1 | One-cycle pulse that ends a clock stretch |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| proc_req | output | 1 | High while a received byte awaits processing |

## Verification
The assertions assume that proc_done arrives only as an answer to a raised proc_req, and that the host does not create START or STOP while the block holds SCL low. They also assume that each SCL level lasts several system clocks, so the synchronised copy lags the line by less than half an SCL phase. The bench host waits ten system clocks per quarter bit and, after releasing SCL, waits for the line to read high. Its responder pulses proc_done once, thirty cycles after it sees proc_req. It changes SDA only while SCL is low, except when it makes START and STOP.

// File: rtl/i2c_regslave_pkg.sv
package i2c_regslave_pkg;

    localparam int REG_AW = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_HOLD,
        ST_ACK,
        ST_SEND,
        ST_HACK
    } slv_state_t;

    // Indices that refuse writes while normal access is selected
    function automatic logic locked_in_normal(input logic [REG_AW-1:0] idx);
        return (idx >= 8'h06 && idx <= 8'h09) ||
               (idx == 8'h0C) || (idx == 8'h0D) ||
               (idx >= 8'h10 && idx <= 8'h17) ||
               (idx == 8'h50) || (idx == 8'h51) ||
               (idx >= 8'h57 && idx <= 8'h60) ||
               (idx == 8'h7E);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q1, sda_q1, scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q1 <= 1'b1;
            sda_q1 <= 1'b1;
            scl_s  <= 1'b1;
            sda_s  <= 1'b1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_q1 <= scl_in;
            sda_q1 <= sda_in;
            scl_s  <= scl_q1;
            sda_s  <= sda_q1;
            scl_d  <= scl_s;
            sda_d  <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_regfile.sv
module i2c_regfile
    import i2c_regslave_pkg::*;
#(
    parameter logic [REG_AW-1:0] DEV_REG     = 8'hFE,
    parameter logic [6:0]        DEV_DEFAULT = 7'h3A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [REG_AW-1:0] raddr,
    output logic [7:0]        rdata,
    output logic [6:0]        dev_addr
);
    localparam int NREG = 1 << REG_AW;

    logic [7:0] mem [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++)
                mem[i] <= (i == int'(DEV_REG)) ? {1'b0, DEV_DEFAULT} : 8'h00;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata    = mem[raddr];
    assign dev_addr = mem[DEV_REG][6:0];

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
    import i2c_regslave_pkg::*;
#(
    parameter logic [REG_AW-1:0] DEV_REG     = 8'hFE,
    parameter logic [6:0]        DEV_DEFAULT = 7'h3A
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic setup_mode,
    input  logic proc_done,
    output logic scl_oe,
    output logic sda_oe,
    output logic proc_req
);
    slv_state_t state, state_nx;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [3:0]        bcnt;
    logic [7:0]        sh, tx_sh, rdata;
    logic [REG_AW-1:0] ptr;
    logic [6:0]        dev_addr;
    logic              rw, in_addr, first, host_ack, we, addr_hit;

    i2c_line_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_regfile #(.DEV_REG(DEV_REG), .DEV_DEFAULT(DEV_DEFAULT)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .waddr   (ptr),
        .wdata   (sh),
        .raddr   (ptr),
        .rdata   (rdata),
        .dev_addr(dev_addr)
    );

    assign addr_hit = (sh[7:1] == dev_addr);
    assign we = (state == ST_HOLD) && proc_done && !in_addr && !first &&
                (setup_mode || !locked_in_normal(ptr));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_ADDR: if (scl_fall && bcnt == 4'd8)
                             state_nx = addr_hit ? ST_HOLD : ST_IDLE;
                ST_DATA: if (scl_fall && bcnt == 4'd8) state_nx = ST_HOLD;
                ST_HOLD: if (proc_done) state_nx = ST_ACK;
                ST_ACK:  if (scl_fall) state_nx = rw ? ST_SEND : ST_DATA;
                ST_SEND: if (scl_fall && bcnt == 4'd7) state_nx = ST_HACK;
                ST_HACK: if (scl_fall) state_nx = host_ack ? ST_SEND : ST_IDLE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt     <= '0;
            sh       <= '0;
            tx_sh    <= '0;
            ptr      <= '0;
            rw       <= 1'b0;
            in_addr  <= 1'b0;
            first    <= 1'b0;
            host_ack <= 1'b0;
        end else if (start_det) begin
            bcnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_DATA: begin
                    if (scl_rise) begin
                        sh   <= {sh[6:0], sda_s};
                        bcnt <= bcnt + 4'd1;
                    end
                    if (scl_fall && bcnt == 4'd8) begin
                        in_addr <= (state == ST_ADDR);
                        if (state == ST_ADDR) begin
                            rw    <= sh[0];
                            first <= 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (proc_done && !in_addr) begin
                        if (first) begin
                            ptr   <= sh;
                            first <= 1'b0;
                        end else begin
                            ptr <= ptr + 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bcnt <= '0;
                        if (rw) tx_sh <= rdata;
                    end
                end
                ST_SEND: begin
                    if (scl_fall) begin
                        tx_sh <= {tx_sh[6:0], 1'b0};
                        bcnt  <= bcnt + 4'd1;
                    end
                end
                ST_HACK: begin
                    if (scl_rise) begin
                        host_ack <= !sda_s;
                        ptr      <= ptr + 1'b1;
                    end
                    if (scl_fall && host_ack) begin
                        tx_sh <= rdata;
                        bcnt  <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        scl_oe   = (state == ST_HOLD);
        proc_req = (state == ST_HOLD);
        unique case (state)
            ST_ACK:  sda_oe = 1'b1;
            ST_SEND: sda_oe = ~tx_sh[7];
            default: sda_oe = 1'b0;
        endcase
    end

    // R3
    stretch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_oe) |-> $past(proc_done));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_req && !proc_done) |=> proc_req);

    // R3
    quiet_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proc_req |-> !sda_oe);

    // R10
    sda_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

endmodule

// File: tb/i2c_regslave_tb.sv
module i2c_regslave_tb;

    localparam int Q    = 10;
    localparam int RESP = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic setup_mode = 1'b0, proc_done = 1'b0;
    logic scl_oe, sda_oe, proc_req;
    logic scl_line, sda_line;

    int total = 0, bad = 0, req_cnt = 0;
    bit fin = 1'b0;
    logic [7:0] wbuf [0:7];
    logic [7:0] rbuf [0:7];
    logic all_ack;
    int   min_str;

    always #10 clk = ~clk;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    i2c_regslave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .setup_mode(setup_mode), .proc_done(proc_done),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .proc_req(proc_req)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // processing responder
    initial begin
        forever begin
            @(negedge clk);
            if (proc_req) begin
                req_cnt++;
                tick(RESP);
                proc_done = 1'b1;
                tick(1);
                proc_done = 1'b0;
            end
        end
    end

    task automatic bus_start();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        bus_start();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output int str);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2*Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1;
        str = 0;
        while (!scl_line) begin tick(1); str++; end
        tick(Q);
        ack = !sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = !give_ack; tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    // write pointer then n data bytes from wbuf
    task automatic write_seq(input logic [6:0] dev, input logic [7:0] p, input int n);
        logic a; int s;
        all_ack = 1'b1; min_str = 1000000;
        bus_start();
        send_byte({dev, 1'b0}, a, s); all_ack &= a; if (s < min_str) min_str = s;
        send_byte(p, a, s);           all_ack &= a; if (s < min_str) min_str = s;
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], a, s); all_ack &= a; if (s < min_str) min_str = s;
        end
        bus_stop();
    endtask

    // set pointer, repeated START, read n bytes into rbuf
    task automatic read_seq(input logic [6:0] dev, input logic [7:0] p, input int n);
        logic a; int s;
        bus_start();
        send_byte({dev, 1'b0}, a, s);
        send_byte(p, a, s);
        bus_rstart();
        send_byte({dev, 1'b1}, a, s);
        for (int k = 0; k < n; k++) recv_byte(k != n-1, rbuf[k]);
        bus_stop();
    endtask

    task automatic t_reset();
        tick(5);
        check("R1 scl_oe in reset", {7'd0, scl_oe}, 8'd0);
        check("R1 sda_oe in reset", {7'd0, sda_oe}, 8'd0);
        rst_n = 1'b1; tick(5);
        check("R1 proc_req after reset", {7'd0, proc_req}, 8'd0);
    endtask

    task automatic t_write_read();
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        write_seq(7'h3A, 8'h20, 3);
        check("R4 all bytes acked", {7'd0, all_ack}, 8'd1);
        check("R3 stretch on every byte", {7'd0, min_str > 0}, 8'd1);
        read_seq(7'h3A, 8'h20, 3);
        check("R5 reg 0x20", rbuf[0], 8'hA1);
        check("R5 reg 0x21", rbuf[1], 8'hB2);
        check("R6 reg 0x22 third read byte", rbuf[2], 8'hC3);
    endtask

    task automatic t_ptr_keep();
        logic a; int s; logic [7:0] b;
        bus_start(); send_byte({7'h3A, 1'b0}, a, s); send_byte(8'h20, a, s); bus_stop();
        bus_start(); send_byte({7'h3A, 1'b1}, a, s); recv_byte(1'b0, b); bus_stop();
        check("R10 pointer kept across STOP", b, 8'hA1);
        bus_start(); send_byte({7'h3A, 1'b1}, a, s); recv_byte(1'b0, b); bus_stop();
        check("R6 pointer stepped after NAK byte", b, 8'hB2);
    endtask

    task automatic t_mismatch();
        logic a; int s; int c0;
        c0 = req_cnt;
        bus_start(); send_byte({7'h22, 1'b0}, a, s); bus_stop();
        check("R2 foreign address NAK", {7'd0, a}, 8'd0);
        check("R2 no proc_req on foreign address", 8'(req_cnt - c0), 8'd0);
    endtask

    task automatic t_protect();
        setup_mode = 1'b0;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        wbuf[3] = 8'h44; wbuf[4] = 8'h55; wbuf[5] = 8'h66;
        write_seq(7'h3A, 8'h05, 6);
        check("R4 locked writes still acked", {7'd0, all_ack}, 8'd1);
        read_seq(7'h3A, 8'h05, 6);
        check("R7 0x05 open", rbuf[0], 8'h11);
        check("R7 0x06 locked", rbuf[1], 8'h00);
        check("R7 0x09 locked", rbuf[4], 8'h00);
        check("R7 0x0A open, pointer advanced", rbuf[5], 8'h66);
        wbuf[0] = 8'h99; wbuf[1] = 8'h77;
        write_seq(7'h3A, 8'h60, 2);
        read_seq(7'h3A, 8'h60, 2);
        check("R7 0x60 locked", rbuf[0], 8'h00);
        check("R7 0x61 open", rbuf[1], 8'h77);
        wbuf[0] = 8'h5A;
        write_seq(7'h3A, 8'h7E, 1);
        read_seq(7'h3A, 8'h7E, 1);
        check("R7 0x7E locked", rbuf[0], 8'h00);
    endtask

    task automatic t_setup();
        setup_mode = 1'b1;
        wbuf[0] = 8'hC4;
        write_seq(7'h3A, 8'h06, 1);
        wbuf[0] = 8'hE7;
        write_seq(7'h3A, 8'h7E, 1);
        setup_mode = 1'b0;
        read_seq(7'h3A, 8'h06, 1);
        check("R8 0x06 written in setup", rbuf[0], 8'hC4);
        read_seq(7'h3A, 8'h7E, 1);
        check("R8 0x7E written in setup", rbuf[0], 8'hE7);
    endtask

    task automatic t_devaddr();
        logic a; int s;
        read_seq(7'h3A, 8'hFE, 1);
        check("R9 address register reset value", rbuf[0], 8'h3A);
        wbuf[0] = 8'h15;
        write_seq(7'h3A, 8'hFE, 1);
        bus_start(); send_byte({7'h3A, 1'b0}, a, s); bus_stop();
        check("R9 old address NAK", {7'd0, a}, 8'd0);
        bus_start(); send_byte({7'h15, 1'b0}, a, s); bus_stop();
        check("R9 new address ACK", {7'd0, a}, 8'd1);
        read_seq(7'h15, 8'hFE, 1);
        check("R9 address register readback", rbuf[0], 8'h15);
    endtask

    initial begin
        t_reset();
        t_write_read();
        t_ptr_keep();
        t_mismatch();
        t_protect();
        t_setup();
        t_devaddr();
        tick(20);
        if (!fin) begin
            fin = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(negedge clk);
        if (!fin) begin
            fin = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule